// File: doc/BRIEF.md
# Shift-Add Rectangular-to-Polar Converter

This block takes a signed Cartesian pair (x, y) and returns its length r and its angle theta. The conversion runs as an iterative vectoring-mode CORDIC. A quadrant fold comes first and moves any left half-plane point onto the right half-plane. A fixed count of micro-rotations then drives y toward zero, and the angle of each step comes from a constant arctangent table. A final stage removes the CORDIC gain with a constant built from shifts and adds. The datapath has no multiplier and no divider.

A request is one cycle of `start` together with the operands. The engine is busy for a fixed number of cycles and then pulses `done` for one cycle. At that point `r_out` and `theta_out` carry the result, and they hold it until the next result. The iteration count, the input width, the internal guard bits and the angle width are parameters. They trade precision against latency and area.

Top module: `cordic_polar`

## Requirements
- R1: `r_out` is unsigned with the same scale as the inputs. It lies within 3 LSB of sqrt(x^2+y^2) for every input pair, including the most negative code on both axes.
- R2: `theta_out` is signed radians with TH_W-3 fraction bits (default Q3.13, so pi is about 25736). For inputs of magnitude 256 or more it lies within 6 LSB of atan2(y, x), comparing modulo 2*pi.
- R3: Inputs with x < 0 are folded by +pi/2 (y >= 0) or -pi/2 (y < 0). Angles therefore cover the full -pi..pi range, and the negative x-axis gives about +pi.
- R4: The input (0, 0) gives r_out = 0 and theta_out = 0.
- R5: `done` is a one-cycle pulse that rises ITER+2 clock edges after the edge that accepts `start`. `busy` is high from the accepting edge until `done` rises.
- R6: A `start` while `busy` is high is ignored. The running result is not disturbed and no extra `done` follows.
- R7: After synchronous reset, `done`, `busy`, `r_out` and `theta_out` are all zero.
- R8: `r_out` and `theta_out` change only in the cycle where `done` is high, and otherwise hold their value.
- R9: A micro-rotation uses only add, subtract and arithmetic shift. Gain correction multiplies by about 0.607253 with signed shifted terms.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request pulse, sampled when not busy |
| x_in | input | IN_W | Signed x operand |
| y_in | input | IN_W | Signed y operand |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle result strobe |
| r_out | output | IN_W | Unsigned magnitude |
| theta_out | output | TH_W | Signed angle in radians, TH_W-3 fraction bits |

## Verification
The edge that samples `start` counts as zero. The result and the `done` pulse are due on edge ITER+2. The bench drives its inputs on the falling edge, so it first sees `done` high at the falling edge ITER+3 after the one where it raised `start`. It checks that `done` is low at every earlier falling edge, then samples `r_out` and `theta_out` at that point and checks that `done` has dropped one falling edge later. For the busy case, a second request is placed two cycles into a run. The bench expects the first operands' result at the usual edge and then no `done` for a further ITER+4 cycles.

// File: rtl/cordic_polar_pkg.sv
package cordic_polar_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ROT,
        ST_GAIN,
        ST_FIN
    } cp_state_e;

    // Gain correction 1/1.64676 ~= 2^-1 + 2^-3 - 2^-6 - 2^-9 - 2^-12 + 2^-14 + 2^-16
    localparam int GAIN_TERMS = 7;
    localparam int GAIN_MAX   = 16;
    localparam int GAIN_SH  [GAIN_TERMS] = '{1, 3, 6, 9, 12, 14, 16};
    localparam bit GAIN_NEG [GAIN_TERMS] = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0};

    // atan(2^-i) scaled by 2^frac, rounded
    function automatic int atan_code(input int i, input int frac);
        real v;
        v = $atan(1.0 / (2.0 ** i)) * (2.0 ** frac);
        return $rtoi(v + 0.5);
    endfunction

    function automatic int half_pi_code(input int frac);
        real v;
        v = 2.0 * $atan(1.0) * (2.0 ** frac);
        return $rtoi(v + 0.5);
    endfunction

endpackage

// File: rtl/cordic_prerot.sv
module cordic_prerot
    import cordic_polar_pkg::*;
#(
    parameter int IN_W = 16,
    parameter int DW   = 23,
    parameter int ZW   = 20,
    parameter int ZF   = 16,
    parameter int G    = 4
) (
    input  logic signed [IN_W-1:0] x_in,
    input  logic signed [IN_W-1:0] y_in,
    output logic signed [DW-1:0]   x_o,
    output logic signed [DW-1:0]   y_o,
    output logic signed [ZW-1:0]   z_o,
    output logic                   zero_o
);
    localparam logic signed [ZW-1:0] HALF_PI = ZW'(half_pi_code(ZF));

    logic signed [DW-1:0] xe, ye;

    always_comb begin
        xe = DW'(x_in) <<< G;
        ye = DW'(y_in) <<< G;
        zero_o = (x_in == '0) && (y_in == '0);
        if (!x_in[IN_W-1]) begin
            x_o = xe;
            y_o = ye;
            z_o = '0;
        end else if (!y_in[IN_W-1]) begin
            x_o = ye;
            y_o = -xe;
            z_o = HALF_PI;
        end else begin
            x_o = -ye;
            y_o = xe;
            z_o = -HALF_PI;
        end
    end
endmodule

// File: rtl/cordic_step.sv
module cordic_step #(
    parameter int DW = 23,
    parameter int ZW = 20,
    parameter int SW = 5
) (
    input  logic signed [DW-1:0] x_i,
    input  logic signed [DW-1:0] y_i,
    input  logic signed [ZW-1:0] z_i,
    input  logic        [SW-1:0] sh,
    input  logic signed [ZW-1:0] ang,
    output logic signed [DW-1:0] x_o,
    output logic signed [DW-1:0] y_o,
    output logic signed [ZW-1:0] z_o
);
    logic signed [DW-1:0] xs, ys;

    always_comb begin
        xs = x_i >>> sh;
        ys = y_i >>> sh;
        if (!y_i[DW-1]) begin
            x_o = x_i + ys;
            y_o = y_i - xs;
            z_o = z_i + ang;
        end else begin
            x_o = x_i - ys;
            y_o = y_i + xs;
            z_o = z_i - ang;
        end
    end
endmodule

// File: rtl/cordic_gain.sv
module cordic_gain
    import cordic_polar_pkg::*;
#(
    parameter int DW  = 23,
    parameter int G   = 4,
    parameter int R_W = 16
) (
    input  logic signed [DW-1:0]  mag,
    output logic        [R_W-1:0] r
);
    localparam int XW = DW + GAIN_MAX;
    localparam int TS = GAIN_MAX + G;
    localparam logic signed [XW-1:0] RND = XW'(1) <<< (TS - 1);

    logic signed [XW-1:0] ext, acc, rnd;

    always_comb begin
        ext = $signed({mag, {GAIN_MAX{1'b0}}});
        acc = '0;
        for (int t = 0; t < GAIN_TERMS; t++) begin
            if (GAIN_NEG[t]) acc = acc - (ext >>> GAIN_SH[t]);
            else             acc = acc + (ext >>> GAIN_SH[t]);
        end
        rnd = (acc + RND) >>> TS;
        r   = rnd[R_W-1:0];
    end
endmodule

// File: rtl/cordic_polar.sv
module cordic_polar
    import cordic_polar_pkg::*;
#(
    parameter int IN_W = 16,
    parameter int ITER = 16,
    parameter int G    = 4,
    parameter int TH_W = 16
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   start,
    input  logic signed [IN_W-1:0] x_in,
    input  logic signed [IN_W-1:0] y_in,
    output logic                   busy,
    output logic                   done,
    output logic        [IN_W-1:0] r_out,
    output logic signed [TH_W-1:0] theta_out
);
    localparam int DW      = IN_W + 3 + G;
    localparam int TH_FRAC = TH_W - 3;
    localparam int ZD      = 3;
    localparam int ZF      = TH_FRAC + ZD;
    localparam int ZW      = ZF + 4;
    localparam int SW      = $clog2(ITER + 1);
    localparam int LW      = SW + 2;
    localparam logic signed [ZW-1:0] ZRND = ZW'(1) <<< (ZD - 1);

    cp_state_e state;
    logic        [SW-1:0] it;
    logic signed [DW-1:0] xr, yr, xp, yp, xn, yn;
    logic signed [ZW-1:0] zr, zp, zn, ang, zround;
    logic                 zero_q, zero_p;
    logic        [IN_W-1:0] r_pre, r_comb;
    logic signed [TH_W-1:0] th_pre;
    logic signed [ZW-1:0] atan_tab [ITER];

    for (genvar g = 0; g < ITER; g++) begin : g_tab
        assign atan_tab[g] = ZW'(atan_code(g, ZF));
    end

    assign ang = atan_tab[it];

    cordic_prerot #(.IN_W(IN_W), .DW(DW), .ZW(ZW), .ZF(ZF), .G(G)) u_pre (
        .x_in(x_in), .y_in(y_in), .x_o(xp), .y_o(yp), .z_o(zp), .zero_o(zero_p)
    );

    cordic_step #(.DW(DW), .ZW(ZW), .SW(SW)) u_step (
        .x_i(xr), .y_i(yr), .z_i(zr), .sh(it), .ang(ang),
        .x_o(xn), .y_o(yn), .z_o(zn)
    );

    cordic_gain #(.DW(DW), .G(G), .R_W(IN_W)) u_gain (
        .mag(xr), .r(r_comb)
    );

    assign zround = (zr + ZRND) >>> ZD;
    assign busy   = (state != ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            it        <= '0;
            xr        <= '0;
            yr        <= '0;
            zr        <= '0;
            zero_q    <= 1'b0;
            r_pre     <= '0;
            th_pre    <= '0;
            done      <= 1'b0;
            r_out     <= '0;
            theta_out <= '0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: if (start) begin
                    xr     <= xp;
                    yr     <= yp;
                    zr     <= zp;
                    zero_q <= zero_p;
                    it     <= '0;
                    state  <= ST_ROT;
                end
                ST_ROT: begin
                    xr <= xn;
                    yr <= yn;
                    zr <= zn;
                    it <= it + 1'b1;
                    if (it == SW'(ITER - 1)) state <= ST_GAIN;
                end
                ST_GAIN: begin
                    r_pre  <= r_comb;
                    th_pre <= zround[TH_W-1:0];
                    state  <= ST_FIN;
                end
                ST_FIN: begin
                    r_out     <= zero_q ? '0 : r_pre;
                    theta_out <= zero_q ? '0 : th_pre;
                    done      <= 1'b1;
                    state     <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Edges since the last accepted request, used by the checks below
    logic [LW-1:0] lat_cnt;
    always_ff @(posedge clk) begin
        if (rst)                             lat_cnt <= '1;
        else if (start && state == ST_IDLE) lat_cnt <= '0;
        else if (lat_cnt != '1)             lat_cnt <= lat_cnt + 1'b1;
    end

    // R5
    done_latency_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (lat_cnt == LW'(ITER + 2)));

    // R5
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R6
    busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> (lat_cnt == $past(lat_cnt) + 1'b1));

    // R4
    zero_out_chk: assert property (@(posedge clk) disable iff (rst)
        (done && zero_q) |-> (r_out == '0 && theta_out == '0));

    // R8
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!$stable(r_out) || !$stable(theta_out)) |-> done);

    // R2
    theta_range_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> ($signed(theta_out) <= $signed(TH_W'(25740)) &&
                  $signed(theta_out) >= -$signed(TH_W'(25740))));
endmodule

// File: tb/sim_cordic_polar.sv
module sim_cordic_polar;
    localparam int IN_W = 16;
    localparam int ITER = 16;
    localparam int TH_W = 16;
    localparam real SC  = 8192.0;
    localparam real PI  = 3.14159265358979;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic signed [IN_W-1:0] x_in = '0, y_in = '0;
    logic busy, done;
    logic [IN_W-1:0] r_out;
    logic signed [TH_W-1:0] theta_out;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    cordic_polar #(.IN_W(IN_W), .ITER(ITER), .G(4), .TH_W(TH_W)) u0 (
        .clk(clk), .rst(rst), .start(start), .x_in(x_in), .y_in(y_in),
        .busy(busy), .done(done), .r_out(r_out), .theta_out(theta_out)
    );

    function automatic real exp_r(input int x, input int y);
        return $sqrt(real'(x) * real'(x) + real'(y) * real'(y));
    endfunction

    function automatic real exp_th(input int x, input int y);
        if (x == 0 && y == 0) return 0.0;
        return $atan2(real'(y), real'(x)) * SC;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input real got, input real expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0.2f expected %0.2f", req, what, got, expv);
        end
    endtask

    // Issue one request; optionally inject a second start while busy
    task automatic run_op(input int x, input int y, input bit inject);
        int lat;
        real er, et, d;
        @(negedge clk);
        x_in = IN_W'(x); y_in = IN_W'(y); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        // R5: busy after the accepting edge
        check(busy == 1'b1, "R5", "busy after accept", real'(busy), 1.0);
        while (!done && lat < ITER + 10) begin
            if (inject && lat == 2) begin
                x_in = 16'sd1; y_in = -16'sd30000; start = 1'b1;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            lat++;
        end
        start = 1'b0;
        // R5: done rises ITER+2 edges after accept (seen at falling edge ITER+3)
        check(lat == ITER + 3, "R5", "done latency", real'(lat), real'(ITER + 3));
        er = exp_r(x, y);
        d = real'(r_out) - er;
        check(d <= 3.0 && d >= -3.0, (x == 0 && y == 0) ? "R4" : "R1", "magnitude",
              real'(r_out), er);
        if (er >= 256.0 || er == 0.0) begin
            et = exp_th(x, y);
            d = real'(theta_out) - et;
            if (d > PI * SC) d = d - 2.0 * PI * SC;
            if (d < -PI * SC) d = d + 2.0 * PI * SC;
            check(d <= 6.0 && d >= -6.0, (x < 0) ? "R3" : "R2", "angle",
                  real'(theta_out), et);
        end
        @(negedge clk);
        // R5: single-cycle pulse
        check(done == 1'b0, "R5", "pulse width", real'(done), 0.0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : stim
        int seed;
        logic [IN_W-1:0] r_hold;
        logic signed [TH_W-1:0] t_hold;
        bit extra;
        seed = $urandom(32'd20240611);
        repeat (3) @(negedge clk);
        // R7: reset state
        check(done == 0 && busy == 0 && r_out == 0 && theta_out == 0, "R7",
              "reset outputs", real'(r_out) + real'(theta_out) + real'(done) + real'(busy), 0.0);
        rst = 1'b0;
        @(negedge clk);

        // Directed corners
        run_op(0, 0, 1'b0);              // R4
        run_op(32767, 0, 1'b0);          // R1, R2
        run_op(-32768, 0, 1'b0);         // R3: about +pi
        run_op(0, 32767, 1'b0);          // R2
        run_op(0, -32768, 1'b0);         // R2
        run_op(-20000, -20000, 1'b0);    // R3
        run_op(-20000, 20000, 1'b0);     // R3
        run_op(-32768, -32768, 1'b0);    // R1: largest magnitude
        run_op(1000, -1, 1'b0);          // R2
        run_op(3, -4, 1'b0);             // R1: small vector, R9 shift-add path

        // R8: outputs hold while idle and across a busy phase
        r_hold = r_out; t_hold = theta_out;
        repeat (5) @(negedge clk);
        check(r_out == r_hold && theta_out == t_hold, "R8", "hold while idle",
              real'(r_out), real'(r_hold));

        // R6: start while busy is ignored
        run_op(12345, 23456, 1'b1);
        extra = 1'b0;
        for (int c = 0; c < ITER + 4; c++) begin
            @(negedge clk);
            if (done) extra = 1'b1;
        end
        check(!extra, "R6", "no extra done", real'(extra), 0.0);

        // Constrained random
        for (int k = 0; k < 60; k++) begin
            int xr, yr;
            xr = int'($signed(16'($urandom())));
            yr = int'($signed(16'($urandom())));
            if (k % 4 == 1) xr = -((xr < 0) ? -xr : xr) - 1;
            if (k % 8 == 3) yr = 0;
            run_op(xr, yr, 1'b0);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule